// File: doc/BRIEF.md
# Ferroelectric Memory Identification Probe

This block is a small SPI master sequencer for the host side. It runs once for each start pulse. It learns what kind of ferroelectric serial memory sits on the bus. First it reads the device status and confirms that the part is not busy. Next it reads the multi-byte identification record and checks the manufacturer code. It then decodes the density code into a byte capacity and an address width of two or three bytes. When the record says a serial number exists, the block fetches the serial number as well and stores it with its byte order reversed.

Each command uses its own chip-select frame. The frame carries the opcode and then the response bytes. A short idle gap separates one frame from the next. The results are held until the next start pulse. They are valid only after `done` rises. At that point exactly one of `valid` and `error` is set, and `fault` gives the reason for a failure. Normal memory reads and writes are not part of this block.

Top module: `fram_probe`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done`, `valid` and `error` are all 0.
- R2: The first frame after start sends opcode 0x05 and receives 1 byte. If bit 0 of that byte is 1, the run ends with `error`=1, `fault`=1 (absent) and no further frames. The other status bits have no effect.
- R3: The second frame sends opcode 0x9F and receives 9 identification bytes, numbered 0 to 8 in arrival order. Every command uses exactly one chip-select frame.
- R4: If identification byte 6 is not 0xC2, the run ends with `error`=1 and `fault`=2. This check has priority over the density check.
- R5: If identification byte 7 is below 0x21 or above 0x26, the run ends with `error`=1 and `fault`=3.
- R6: On success, `capacity` equals 2^(byte7 − 0x21 + 14) bytes.
- R7: On success, `addr_bytes` is 3 when the capacity is above 65536 bytes, and 2 otherwise.
- R8: A third frame, with opcode 0xC3 and 8 response bytes, happens only when identification byte 8 is nonzero. When no serial frame happens, `serial` reads 0.
- R9: Serial byte k in arrival order (k = 0..7) is stored in `serial[8*(7-k)+7 : 8*(7-k)]`. The last byte received therefore lands in bits 7:0.
- R10: `valid` and `error` are never 1 together. Both stay 0 from the start pulse until `done` rises. A start pulse received while `busy` is 1 is ignored.
- R11: The SPI link uses mode 0. `spi_sclk` is low while idle and whenever `spi_cs_n` is high. Data is sent most significant bit first. `spi_mosi` is stable at each rising edge of `spi_sclk`, and `spi_miso` is sampled on that same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a probe |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Data from the master to the memory |
| spi_miso | input | 1 | Data from the memory to the master |
| busy | output | 1 | High while a probe is running |
| done | output | 1 | High once a probe has finished, until the next start |
| valid | output | 1 | The probe succeeded and the results hold |
| error | output | 1 | The probe failed |
| fault | output | 2 | Failure cause: 0 none, 1 absent, 2 wrong vendor, 3 density out of range |
| capacity | output | CAP_W (20) | Device size in bytes |
| addr_bytes | output | 2 | Address width in bytes (2 or 3) |
| serial | output | 8*SN_LEN (64) | Serial number after byte reversal |

## Verification
The hardest conditions to reach from the ports depend on what the memory sends back. The two ends of the density range sit right next to invalid codes, a bad vendor can appear together with a bad density, and the optional serial frame is taken only for a nonzero flag byte. A behavioural slave in the bench answers each opcode from values that every case sets, so each of these branches is driven deliberately. The bench also sends a second start pulse in the middle of a serial-reading run. If that pulse were not ignored, an extra status frame would appear in the frame log that the slave records.

// File: rtl/fram_probe_pkg.sv
package fram_probe_pkg;

   localparam logic [7:0] OP_STATUS = 8'h05;
   localparam logic [7:0] OP_IDENT  = 8'h9F;
   localparam logic [7:0] OP_SERIAL = 8'hC3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_OPEN,
      S_CMD,
      S_DATA,
      S_EVAL,
      S_GAP
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_STAT,
      PH_IDENT,
      PH_SERIAL
   } phase_t;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_ABSENT  = 2'd1,
      FLT_VENDOR  = 2'd2,
      FLT_DENSITY = 2'd3
   } fault_t;

endpackage

// File: rtl/fram_spi_byte.sv
module fram_spi_byte #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       byte_done,
   output logic [7:0] rx_byte
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic       busy_q;
   logic       tick;
   logic [2:0] bitn;
   logic [7:0] shreg;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!busy_q || tick) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
         end
         assign tick = busy_q && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         sclk      <= 1'b0;
         mosi      <= 1'b0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
         bitn      <= '0;
         shreg     <= '0;
      end else begin
         byte_done <= 1'b0;
         if (go && !busy_q) begin
            busy_q <= 1'b1;
            shreg  <= tx_byte;
            mosi   <= tx_byte[7];
            bitn   <= '0;
            sclk   <= 1'b0;
         end else if (tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  busy_q    <= 1'b0;
                  byte_done <= 1'b1;
                  mosi      <= 1'b0;
               end else begin
                  bitn  <= bitn + 1'b1;
                  shreg <= {shreg[6:0], 1'b0};
                  mosi  <= shreg[6];
               end
            end
         end
      end
   end

endmodule

// File: rtl/fram_id_decode.sv
module fram_id_decode #(
   parameter logic [7:0] VENDOR_CODE = 8'hC2,
   parameter logic [7:0] DENS_MIN    = 8'h21,
   parameter logic [7:0] DENS_MAX    = 8'h26,
   parameter int         BASE_LOG2   = 14,
   parameter int         WIDE_LIM    = 65536,
   parameter int         CAP_W       = 20
) (
   input  logic [7:0]       vend,
   input  logic [7:0]       dens,
   input  logic [7:0]       flag,
   output logic             vend_ok,
   output logic             dens_ok,
   output logic             has_sn,
   output logic [CAP_W-1:0] cap,
   output logic [1:0]       width
);

   logic [7:0] shamt;

   always_comb begin
      vend_ok = (vend == VENDOR_CODE);
      dens_ok = (dens >= DENS_MIN) && (dens <= DENS_MAX);
      has_sn  = |flag;
      shamt   = dens - DENS_MIN + 8'(BASE_LOG2);
      cap     = dens_ok ? ({{(CAP_W-1){1'b0}}, 1'b1} << shamt) : '0;
      width   = (cap > CAP_W'(WIDE_LIM)) ? 2'd3 : 2'd2;
   end

endmodule

// File: rtl/fram_probe_seq.sv
module fram_probe_seq
   import fram_probe_pkg::*;
#(
   parameter int ID_LEN     = 9,
   parameter int SN_LEN     = 8,
   parameter int VENDOR_IDX = 6,
   parameter int DENS_IDX   = 7,
   parameter int FLAG_IDX   = 8,
   parameter int GAP_CYC    = 2,
   parameter int CAP_W      = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                byte_done,
   input  logic [7:0]          rx_byte,
   output logic                go,
   output logic [7:0]          tx_byte,
   output logic                cs_n,
   output logic [7:0]          vend_q,
   output logic [7:0]          dens_q,
   output logic [7:0]          flag_q,
   input  logic                vend_ok,
   input  logic                dens_ok,
   input  logic                has_sn,
   input  logic [CAP_W-1:0]    cap_in,
   input  logic [1:0]          width_in,
   output logic                busy,
   output logic                done,
   output logic                valid,
   output logic                error,
   output logic [1:0]          fault,
   output logic [CAP_W-1:0]    capacity,
   output logic [1:0]          addr_bytes,
   output logic [8*SN_LEN-1:0] serial
);

   localparam int MAXLEN = (ID_LEN > SN_LEN) ? ID_LEN : SN_LEN;
   localparam int IW     = $clog2(MAXLEN);
   localparam int GW     = $clog2(GAP_CYC + 1);

   seq_state_t      state;
   phase_t          phase;
   fault_t          fault_q;
   logic [IW-1:0]   idx;
   logic [IW-1:0]   last_idx;
   logic [GW-1:0]   gap;
   logic            stat_busy_q;

   function automatic logic [7:0] opcode_of(phase_t p);
      case (p)
         PH_STAT:   return OP_STATUS;
         PH_IDENT:  return OP_IDENT;
         default:   return OP_SERIAL;
      endcase
   endfunction

   always_comb begin
      case (phase)
         PH_STAT:  last_idx = '0;
         PH_IDENT: last_idx = IW'(ID_LEN - 1);
         default:  last_idx = IW'(SN_LEN - 1);
      endcase
   end

   assign fault = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         phase       <= PH_STAT;
         fault_q     <= FLT_NONE;
         idx         <= '0;
         gap         <= '0;
         stat_busy_q <= 1'b0;
         go          <= 1'b0;
         tx_byte     <= '0;
         cs_n        <= 1'b1;
         vend_q      <= '0;
         dens_q      <= '0;
         flag_q      <= '0;
         busy        <= 1'b0;
         done        <= 1'b0;
         valid       <= 1'b0;
         error       <= 1'b0;
         capacity    <= '0;
         addr_bytes  <= '0;
         serial      <= '0;
      end else begin
         go <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  busy       <= 1'b1;
                  done       <= 1'b0;
                  valid      <= 1'b0;
                  error      <= 1'b0;
                  fault_q    <= FLT_NONE;
                  capacity   <= '0;
                  addr_bytes <= '0;
                  serial     <= '0;
                  phase      <= PH_STAT;
                  state      <= S_OPEN;
               end
            end
            S_OPEN: begin
               cs_n    <= 1'b0;
               go      <= 1'b1;
               tx_byte <= opcode_of(phase);
               idx     <= '0;
               state   <= S_CMD;
            end
            S_CMD: begin
               if (byte_done) begin
                  go      <= 1'b1;
                  tx_byte <= 8'h00;
                  state   <= S_DATA;
               end
            end
            S_DATA: begin
               if (byte_done) begin
                  case (phase)
                     PH_STAT: stat_busy_q <= rx_byte[0];
                     PH_IDENT: begin
                        if (idx == IW'(VENDOR_IDX)) vend_q <= rx_byte;
                        if (idx == IW'(DENS_IDX))   dens_q <= rx_byte;
                        if (idx == IW'(FLAG_IDX))   flag_q <= rx_byte;
                     end
                     default: serial <= {serial[8*SN_LEN-9:0], rx_byte};
                  endcase
                  if (idx == last_idx) begin
                     cs_n  <= 1'b1;
                     state <= S_EVAL;
                  end else begin
                     idx <= idx + 1'b1;
                     go  <= 1'b1;
                  end
               end
            end
            S_EVAL: begin
               case (phase)
                  PH_STAT: begin
                     if (stat_busy_q) begin
                        fault_q <= FLT_ABSENT;
                        error   <= 1'b1;
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        state   <= S_IDLE;
                     end else begin
                        phase <= PH_IDENT;
                        state <= S_GAP;
                     end
                  end
                  PH_IDENT: begin
                     if (!vend_ok || !dens_ok) begin
                        fault_q <= !vend_ok ? FLT_VENDOR : FLT_DENSITY;
                        error   <= 1'b1;
                        done    <= 1'b1;
                        busy    <= 1'b0;
                        state   <= S_IDLE;
                     end else begin
                        capacity   <= cap_in;
                        addr_bytes <= width_in;
                        if (has_sn) begin
                           phase <= PH_SERIAL;
                           state <= S_GAP;
                        end else begin
                           valid <= 1'b1;
                           done  <= 1'b1;
                           busy  <= 1'b0;
                           state <= S_IDLE;
                        end
                     end
                  end
                  default: begin
                     valid <= 1'b1;
                     done  <= 1'b1;
                     busy  <= 1'b0;
                     state <= S_IDLE;
                  end
               endcase
            end
            S_GAP: begin
               if (gap == GW'(GAP_CYC - 1)) begin
                  gap   <= '0;
                  state <= S_OPEN;
               end else begin
                  gap <= gap + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fram_probe.sv
module fram_probe #(
   parameter int         HALF_DIV    = 2,
   parameter int         GAP_CYC     = 2,
   parameter int         ID_LEN      = 9,
   parameter int         SN_LEN      = 8,
   parameter int         VENDOR_IDX  = 6,
   parameter int         DENS_IDX    = 7,
   parameter int         FLAG_IDX    = 8,
   parameter logic [7:0] VENDOR_CODE = 8'hC2,
   parameter logic [7:0] DENS_MIN    = 8'h21,
   parameter logic [7:0] DENS_MAX    = 8'h26,
   parameter int         BASE_LOG2   = 14,
   parameter int         WIDE_LIM    = 65536,
   localparam int        CAP_W       = BASE_LOG2 + int'(DENS_MAX) - int'(DENS_MIN) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                spi_sclk,
   output logic                spi_cs_n,
   output logic                spi_mosi,
   input  logic                spi_miso,
   output logic                busy,
   output logic                done,
   output logic                valid,
   output logic                error,
   output logic [1:0]          fault,
   output logic [CAP_W-1:0]    capacity,
   output logic [1:0]          addr_bytes,
   output logic [8*SN_LEN-1:0] serial
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (DENS_MAX < DENS_MIN) begin : g_bad_dens
         $error("density range is empty");
      end
      if (VENDOR_IDX >= ID_LEN || DENS_IDX >= ID_LEN || FLAG_IDX >= ID_LEN) begin : g_bad_idx
         $error("identification field index beyond record length");
      end
      if (SN_LEN < 2) begin : g_bad_sn
         $error("SN_LEN must be at least 2");
      end
   endgenerate

   logic             go;
   logic [7:0]       tx_byte;
   logic             byte_done;
   logic [7:0]       rx_byte;
   logic [7:0]       vend_q;
   logic [7:0]       dens_q;
   logic [7:0]       flag_q;
   logic             vend_ok;
   logic             dens_ok;
   logic             has_sn;
   logic [CAP_W-1:0] cap_dec;
   logic [1:0]       width_dec;

   fram_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tx_byte   (tx_byte),
      .miso      (spi_miso),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   fram_id_decode #(
      .VENDOR_CODE (VENDOR_CODE),
      .DENS_MIN    (DENS_MIN),
      .DENS_MAX    (DENS_MAX),
      .BASE_LOG2   (BASE_LOG2),
      .WIDE_LIM    (WIDE_LIM),
      .CAP_W       (CAP_W)
   ) u_dec (
      .vend    (vend_q),
      .dens    (dens_q),
      .flag    (flag_q),
      .vend_ok (vend_ok),
      .dens_ok (dens_ok),
      .has_sn  (has_sn),
      .cap     (cap_dec),
      .width   (width_dec)
   );

   fram_probe_seq #(
      .ID_LEN     (ID_LEN),
      .SN_LEN     (SN_LEN),
      .VENDOR_IDX (VENDOR_IDX),
      .DENS_IDX   (DENS_IDX),
      .FLAG_IDX   (FLAG_IDX),
      .GAP_CYC    (GAP_CYC),
      .CAP_W      (CAP_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .go         (go),
      .tx_byte    (tx_byte),
      .cs_n       (spi_cs_n),
      .vend_q     (vend_q),
      .dens_q     (dens_q),
      .flag_q     (flag_q),
      .vend_ok    (vend_ok),
      .dens_ok    (dens_ok),
      .has_sn     (has_sn),
      .cap_in     (cap_dec),
      .width_in   (width_dec),
      .busy       (busy),
      .done       (done),
      .valid      (valid),
      .error      (error),
      .fault      (fault),
      .capacity   (capacity),
      .addr_bytes (addr_bytes),
      .serial     (serial)
   );

endmodule

// File: rtl/fram_probe_chk.sv
module fram_probe_chk #(
   parameter int CAP_W    = 20,
   parameter int WIDE_LIM = 65536
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi,
   input logic             busy,
   input logic             done,
   input logic             valid,
   input logic             error,
   input logic [1:0]       fault,
   input logic [CAP_W-1:0] capacity,
   input logic [1:0]       addr_bytes
);

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && error));

   a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!valid && !error && !done));

   a_r10_result_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      (valid || error) |-> done);

   a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   a_r11_mosi_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));

   a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($countones(capacity) == 1));

   a_r7_width_matches: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (addr_bytes == ((capacity > CAP_W'(WIDE_LIM)) ? 2'd3 : 2'd2)));

   a_r2_fault_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (fault != 2'd0));

   a_r4_no_fault_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (fault == 2'd0));

endmodule

bind fram_probe fram_probe_chk #(.CAP_W(CAP_W), .WIDE_LIM(WIDE_LIM)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi_sclk   (spi_sclk),
   .spi_cs_n   (spi_cs_n),
   .spi_mosi   (spi_mosi),
   .busy       (busy),
   .done       (done),
   .valid      (valid),
   .error      (error),
   .fault      (fault),
   .capacity   (capacity),
   .addr_bytes (addr_bytes)
);

// File: tb/sim_fram_probe.sv
`timescale 1ns/1ps
module sim_fram_probe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        spi_sclk;
   logic        spi_cs_n;
   logic        spi_mosi;
   logic        spi_miso = 1'b0;
   logic        busy;
   logic        done;
   logic        valid;
   logic        error;
   logic [1:0]  fault;
   logic [19:0] capacity;
   logic [1:0]  addr_bytes;
   logic [63:0] serial;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int mon_err = 0;
   bit in_run = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fram_probe u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .busy(busy), .done(done), .valid(valid), .error(error), .fault(fault),
      .capacity(capacity), .addr_bytes(addr_bytes), .serial(serial)
   );

   // behavioural memory: answers by opcode from the case settings
   logic [7:0] g_stat;
   logic [7:0] g_id [9];
   logic [7:0] g_sn [8];
   int         fr_op[$];
   int         fr_len[$];
   int         rise_cnt = 0;
   logic [7:0] op_sh = 8'h00;
   logic       p_sclk = 1'b0;
   logic       p_cs = 1'b1;

   function automatic logic [7:0] resp(int k);
      if (op_sh == 8'h05) return (k == 0) ? g_stat : 8'h00;
      if (op_sh == 8'h9F) return (k < 9) ? g_id[k] : 8'h00;
      if (op_sh == 8'hC3) return (k < 8) ? g_sn[k] : 8'h00;
      return 8'h00;
   endfunction

   always @(spi_sclk or spi_cs_n) begin
      logic [7:0] rb;
      if (p_cs && !spi_cs_n) begin
         rise_cnt = 0; op_sh = 8'h00; spi_miso = 1'b0;
      end else if (!p_cs && spi_cs_n) begin
         fr_op.push_back(int'(op_sh));
         fr_len.push_back(rise_cnt > 8 ? (rise_cnt - 8) / 8 : 0);
      end
      if (!spi_cs_n && !p_sclk && spi_sclk) begin
         rise_cnt++;
         if (rise_cnt <= 8) op_sh = {op_sh[6:0], spi_mosi};
      end
      if (!spi_cs_n && p_sclk && !spi_sclk && rise_cnt >= 8) begin
         rb = resp((rise_cnt - 8) / 8);
         spi_miso = rb[7 - ((rise_cnt - 8) % 8)];
      end
      p_sclk = spi_sclk;
      p_cs = spi_cs_n;
   end

   // per-clock comparison of the output protocol against the model
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (valid && error) mon_err++;
         if (in_run && !done && (valid || error)) mon_err++;
         if (spi_cs_n && spi_sclk) mon_err++;
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(string name, logic [7:0] st, logic [7:0] v, logic [7:0] d,
                           logic [7:0] f, bit poke);
      int         exp_fault;
      longint     exp_cap;
      int         exp_w;
      logic [63:0] exp_ser;
      int         e_op[$];
      int         e_len[$];
      int         n;
      g_stat = st;
      for (int i = 0; i < 6; i++) g_id[i] = 8'h5A ^ 8'(i * 37);
      g_id[6] = v; g_id[7] = d; g_id[8] = f;
      for (int k = 0; k < 8; k++) g_sn[k] = 8'h31 + 8'(k * 29) ^ d;
      fr_op.delete(); fr_len.delete();
      exp_ser = '0; exp_cap = 0; exp_w = 0;
      e_op.push_back(8'h05); e_len.push_back(1);
      if (st[0]) exp_fault = 1;
      else begin
         e_op.push_back(8'h9F); e_len.push_back(9);
         if (v != 8'hC2) exp_fault = 2;
         else if (d < 8'h21 || d > 8'h26) exp_fault = 3;
         else begin
            exp_fault = 0;
            exp_cap = longint'(1) << (int'(d) - 'h21 + 14);
            exp_w = (exp_cap > 65536) ? 3 : 2;
            if (f != 0) begin
               e_op.push_back(8'hC3); e_len.push_back(8);
               for (int k = 0; k < 8; k++) exp_ser[8*(7-k) +: 8] = g_sn[k];
            end
         end
      end
      mon_err = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) begin start = 1'b0; in_run = 1; end
      if (poke) begin
         repeat (60) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      n = 0;
      while (!done && n < 8000) begin @(negedge clk); n++; end
      in_run = 0;
      chk("R10", {name, " done reached"}, done, 1);
      repeat (4) @(negedge clk);
      chk("R10", {name, " per-cycle monitor"}, mon_err, 0);
      chk(exp_fault == 0 ? "R10" : "R2", {name, " valid"}, valid, exp_fault == 0);
      chk(exp_fault == 0 ? "R10" : "R4", {name, " error"}, error, exp_fault != 0);
      chk(exp_fault == 1 ? "R2" : (exp_fault == 3 ? "R5" : "R4"), {name, " fault"}, fault, exp_fault);
      chk("R3", {name, " frame count"}, fr_op.size(), e_op.size());
      for (int i = 0; i < e_op.size() && i < fr_op.size(); i++) begin
         chk(e_op[i] == 8'hC3 ? "R8" : "R3", {name, " frame opcode"}, fr_op[i], e_op[i]);
         chk("R3", {name, " frame length"}, fr_len[i], e_len[i]);
      end
      if (exp_fault == 0) begin
         chk("R6", {name, " capacity"}, capacity, exp_cap);
         chk("R7", {name, " addr_bytes"}, addr_bytes, exp_w);
         chk(f != 0 ? "R9" : "R8", {name, " serial"}, serial, exp_ser);
      end
      chk("R10", {name, " busy low at end"}, busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset cs_n", spi_cs_n, 1);
      chk("R1", "reset sclk", spi_sclk, 0);
      chk("R1", "reset flags", {busy, done, valid, error}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle after release", {spi_cs_n, spi_sclk, done}, 3'b100);

      run_case("absent",        8'h01, 8'hC2, 8'h22, 8'h01, 0); // R2
      run_case("busy-bits-ok",  8'hFE, 8'hC1, 8'h22, 8'h00, 0); // R2 other bits, R4
      run_case("dens-low",      8'h00, 8'hC2, 8'h20, 8'h01, 0); // R5
      run_case("dens-high",     8'h00, 8'hC2, 8'h27, 8'h00, 0); // R5
      run_case("both-bad",      8'h00, 8'h00, 8'h30, 8'h00, 0); // R4 priority
      run_case("min-no-sn",     8'h00, 8'hC2, 8'h21, 8'h00, 0); // R6 R8
      run_case("64k-sn",        8'h00, 8'hC2, 8'h23, 8'h01, 0); // R7 boundary, R9
      run_case("128k-no-sn",    8'h00, 8'hC2, 8'h24, 8'h00, 0); // R7
      run_case("max-sn-poke",   8'h00, 8'hC2, 8'h26, 8'h80, 1); // R10 ignored start
      run_case("256k-sn",       8'h02, 8'hC2, 8'h25, 8'h05, 0); // R9
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule